// File: doc/BRIEF.md
# Space-Vector Sector and Duty Generator

This block converts a stator voltage vector into three unsigned phase duty cycles for a three-phase inverter. The vector arrives as signed alpha and beta components in 3.21 fixed point (24 bits: sign, two integer bits, 21 fraction bits). The block classifies the vector into a sector code from three sign tests. It then forms per-phase signed voltages according to one of four modulation styles and maps each of them to a 24-bit unsigned duty.

A controller places the vector and a mode on the inputs and pulses `start`. The block captures them and, one cycle later, presents the three duties and the sector code together with a one-cycle `done` pulse. The results stay on the outputs until the next completed request.

Top module: `svm_duty_gen`

## Requirements
- R1: While `rst_n` is low, `done` is 0, `sector` is 0 and all three duty outputs are 0.
- R2: A `start` seen high at a rising edge while the block is idle captures `v_alpha`, `v_beta` and `mode`. On the next rising edge the outputs update and `done` goes high for exactly one cycle. A `start` that arrives in the cycle after a capture is ignored.
- R3: `sector` equals 1·(X > 0) + 2·(Z < 0) + 4·(Y < 0). Code 7 never occurs.
- R4: The helper terms are X = beta, Y = hb + ra and Z = hb − ra. Here hb = floor(beta/2), and ra = floor(alpha·K / 2^23) with K = 0x6ED9EA (√3/2 in 1.23). The terms are kept wide enough that they never wrap.
- R5: Mode 0 (symmetric):
  - Sectors 3 and 4 give a = X−Z, b = X+Z, c = Z−X.
  - Sectors 1 and 6 give a = Y−Z, b = Y+Z, c = −(Y+Z).
  - Sectors 2 and 5 give a = Y−X, b = X−Y, c = −X−Y.
  - Sectors 0 and 7 give zero.
  - Each phase duty is the saturated value plus 0x800000, modulo 2^24.
- R6: Mode 1 (bottom-clamped) sets one phase to 0 in each sector:
  - Sector 3: a = X−Z, b = X, c = 0.
  - Sector 1: a = Y, b = Y+Z, c = 0.
  - Sector 5: a = 0, b = X−Y, c = −Y.
  - Sector 4: a = 0, b = Z, c = Z−X.
  - Sector 6: a = −Z, b = 0, c = −Z−Y.
  - Sector 2: a = Y−X, b = 0, c = −X.
  - Sectors 0 and 7 give all zero.
  - Each duty is the saturated value shifted left by 1 (24 bits).
- R7: Mode 2 (top-clamped) sets one phase to −1 (all ones) in each sector:
  - Sector 3: a = −1, b = Z−1, c = Z−1−X.
  - Sector 1: a = −1−Z, b = −1, c = −1−Z−Y.
  - Sector 5: a = Y−X−1, b = −1, c = −1−X.
  - Sector 4: a = X−1−Z, b = X−1, c = −1.
  - Sector 6: a = Y−1, b = Y+Z−1, c = −1.
  - Sector 2: a = −1, b = X−Y−1, c = −1−Y.
  - Sectors 0 and 7 give −1 on all phases.
  - Duties are mapped as in R6, so a −1 phase reads 0xFFFFF8.
- R8: Mode 3 (inverse Clarke) gives a = alpha, b = rb − ha and c = −ha − rb. Here ha = floor(alpha/2) and rb = floor(beta·K / 2^23). Duties are mapped as in R5.
- R9: Saturation converts a 3.21 value v to 1.23:
  - A value above 0x1FFFFF becomes 0x7FFFFF.
  - A value below −0x200000 becomes 0x800001.
  - Otherwise the result is v shifted left by 2.
- R10: The duty and sector outputs change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; captures vector and mode when idle |
| mode | input | 2 | 0 symmetric, 1 bottom-clamped, 2 top-clamped, 3 inverse Clarke |
| v_alpha | input | 24 | Alpha component, signed 3.21 |
| v_beta | input | 24 | Beta component, signed 3.21 |
| done | output | 1 | One-cycle pulse marking new results |
| sector | output | 3 | Sector code of the captured vector |
| duty_a | output | 24 | Phase A unsigned duty |
| duty_b | output | 24 | Phase B unsigned duty |
| duty_c | output | 24 | Phase C unsigned duty |

## Verification
A wrong sector decision shows on `sector` in the same `done` cycle. It also shows in the duties, because a neighbouring sector selects a different formula, so the error is visible two edges after `start`. A wrong sign convention in a helper term, or a dropped saturation branch, appears as a miscompare only for vectors on one side of a boundary. The sweep therefore covers a grid of both signs across all four modes, plus vectors placed just inside and just outside the saturation limits. A broken capture or busy flag shows as `done` at the wrong edge, or as a second request leaking through, and is seen within three cycles.

// File: rtl/svm_duty_gen.sv
module svm_duty_gen #(
  parameter int DW = 24,
  parameter logic [DW-1:0] ROOT3_HALF = 24'h6ED9EA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic signed [DW-1:0] v_alpha,
  input  logic signed [DW-1:0] v_beta,
  output logic                 done,
  output logic [2:0]           sector,
  output logic [DW-1:0]        duty_a,
  output logic [DW-1:0]        duty_b,
  output logic [DW-1:0]        duty_c
);
  localparam int IW = DW + 3;
  localparam int PW = 2 * DW + 1;
  typedef logic signed [IW-1:0] wide_t;
  localparam wide_t LIM_HI = wide_t'((64'sd1 <<< (DW - 3)) - 64'sd1);
  localparam wide_t LIM_LO = -LIM_HI - wide_t'(1);
  localparam wide_t ONE    = wide_t'(1);

  logic                 busy;
  logic [1:0]           mode_q;
  logic signed [DW-1:0] alpha_q, beta_q;

  logic signed [PW-1:0] prod_a, prod_b;
  wide_t ra, rb, ha, hb, tx, ty, tz;
  wide_t pa, pb, pc;
  logic [2:0] sec_c;

  assign prod_a = alpha_q * $signed({1'b0, ROOT3_HALF});
  assign prod_b = beta_q  * $signed({1'b0, ROOT3_HALF});
  assign ra = wide_t'(prod_a >>> (DW - 1));
  assign rb = wide_t'(prod_b >>> (DW - 1));
  assign ha = wide_t'(alpha_q) >>> 1;
  assign hb = wide_t'(beta_q) >>> 1;
  assign tx = wide_t'(beta_q);
  assign ty = hb + ra;
  assign tz = hb - ra;
  assign sec_c = {ty < 0, tz < 0, tx > 0};

  always_comb begin
    pa = '0; pb = '0; pc = '0;
    case (mode_q)
      2'd0: begin
        case (sec_c)
          3'd3, 3'd4: begin pa = tx - tz; pb = tx + tz; pc = tz - tx; end
          3'd1, 3'd6: begin pa = ty - tz; pb = ty + tz; pc = -(ty + tz); end
          3'd2, 3'd5: begin pa = ty - tx; pb = tx - ty; pc = -tx - ty; end
          default: ;
        endcase
      end
      2'd1: begin
        case (sec_c)
          3'd3: begin pa = tx - tz; pb = tx;      pc = '0;      end
          3'd1: begin pa = ty;      pb = ty + tz; pc = '0;      end
          3'd5: begin pa = '0;      pb = tx - ty; pc = -ty;     end
          3'd4: begin pa = '0;      pb = tz;      pc = tz - tx; end
          3'd6: begin pa = -tz;     pb = '0;      pc = -tz - ty; end
          3'd2: begin pa = ty - tx; pb = '0;      pc = -tx;     end
          default: ;
        endcase
      end
      2'd2: begin
        pa = -ONE; pb = -ONE; pc = -ONE;
        case (sec_c)
          3'd3: begin pb = tz - ONE;      pc = tz - ONE - tx; end
          3'd1: begin pa = -ONE - tz;     pc = -ONE - tz - ty; end
          3'd5: begin pa = ty - tx - ONE; pc = -ONE - tx;     end
          3'd4: begin pa = tx - ONE - tz; pb = tx - ONE;      end
          3'd6: begin pa = ty - ONE;      pb = ty + tz - ONE; end
          3'd2: begin pb = tx - ty - ONE; pc = -ONE - ty;     end
          default: ;
        endcase
      end
      default: begin
        pa = wide_t'(alpha_q);
        pb = rb - ha;
        pc = -ha - rb;
      end
    endcase
  end

  function automatic logic [DW-1:0] sat_shift(input wide_t v);
    if (v > LIM_HI)      return {1'b0, {(DW-1){1'b1}}};
    else if (v < LIM_LO) return {1'b1, {(DW-2){1'b0}}, 1'b1};
    else                 return {v[DW-3:0], 2'b00};
  endfunction

  function automatic logic [DW-1:0] to_duty(input wide_t v, input logic clamped);
    logic [DW-1:0] s;
    s = sat_shift(v);
    if (clamped) return {s[DW-2:0], 1'b0};
    else         return {~s[DW-1], s[DW-2:0]};
  endfunction

  logic clamp_sel;
  assign clamp_sel = (mode_q == 2'd1) || (mode_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mode_q  <= '0;
      alpha_q <= '0;
      beta_q  <= '0;
      done    <= 1'b0;
      sector  <= '0;
      duty_a  <= '0;
      duty_b  <= '0;
      duty_c  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        sector <= sec_c;
        duty_a <= to_duty(pa, clamp_sel);
        duty_b <= to_duty(pb, clamp_sel);
        duty_c <= to_duty(pc, clamp_sel);
      end else if (start) begin
        busy    <= 1'b1;
        mode_q  <= mode;
        alpha_q <= v_alpha;
        beta_q  <= v_beta;
      end
    end
  end
endmodule

// File: rtl/svm_duty_gen_chk.sv
module svm_duty_gen_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [1:0]    mode_q,
  input logic          done,
  input logic [2:0]    sector,
  input logic [DW-1:0] duty_a,
  input logic [DW-1:0] duty_b,
  input logic [DW-1:0] duty_c
);
  localparam logic [DW-1:0] TOP_DUTY = {{(DW-3){1'b1}}, 3'b000};

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy); // R2
  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) busy |=> done && !busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_NO_SECTOR7: assert property (@(posedge clk) disable iff (!rst_n) done |-> sector != 3'd7); // R3
  AST_BOTTOM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'd1 |-> (duty_a == '0 || duty_b == '0 || duty_c == '0)); // R6
  AST_TOP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'd2 |-> (duty_a == TOP_DUTY || duty_b == TOP_DUTY || duty_c == TOP_DUTY)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(duty_a) && $stable(duty_b) && $stable(duty_c) && $stable(sector)); // R10
endmodule

bind svm_duty_gen svm_duty_gen_chk #(.DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mode_q(mode_q),
  .done(done), .sector(sector), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c)
);

// File: tb/svm_duty_gen_test.sv
`timescale 1ns/1ps
module svm_duty_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic signed [23:0] v_alpha = '0, v_beta = '0;
  logic done;
  logic [2:0] sector;
  logic [23:0] duty_a, duty_b, duty_c;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  svm_duty_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .v_alpha(v_alpha), .v_beta(v_beta), .done(done), .sector(sector),
    .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c)
  );

  function automatic longint sat(longint v);
    if (v > 64'sh1FFFFF) return 64'h7FFFFF;
    if (v < -64'sh200000) return 64'h800001;
    return (v * 4) & 64'hFFFFFF;
  endfunction

  function automatic longint map(longint v, int md);
    if (md == 1 || md == 2) return (sat(v) * 2) & 64'hFFFFFF;
    return (sat(v) + 64'h800000) & 64'hFFFFFF;
  endfunction

  task automatic model(input longint al, input longint be, input int md,
                       output longint da, output longint db, output longint dc, output int sc);
    longint k, sa, sb, ha, hb, x, y, z, a, b, c;
    k = 64'h6ED9EA;
    sa = (k * al) >>> 23;
    sb = (k * be) >>> 23;
    ha = al >>> 1;
    hb = be >>> 1;
    x = be; y = hb + sa; z = hb - sa;
    sc = (x > 0 ? 1 : 0) + (z < 0 ? 2 : 0) + (y < 0 ? 4 : 0);
    a = 0; b = 0; c = 0;
    if (md == 0) begin
      if (sc == 3 || sc == 4) begin a = x - z; b = x + z; c = z - x; end
      else if (sc == 1 || sc == 6) begin a = y - z; b = y + z; c = -(y + z); end
      else if (sc == 2 || sc == 5) begin b = x - y; a = -b; c = -y - x; end
    end else if (md == 1) begin
      case (sc)
        3: begin b = x; a = x - z; end
        1: begin a = y; b = y + z; end
        5: begin c = -y; b = c + x; end
        4: begin b = z; c = z - x; end
        6: begin a = -z; c = a - y; end
        2: begin c = -x; a = y - x; end
        default: ;
      endcase
    end else if (md == 2) begin
      a = -1; b = -1; c = -1;
      case (sc)
        3: begin b = z - 1; c = b - x; end
        1: begin a = -(1 + z); c = a - y; end
        5: begin c = -1 - x; a = c + y; end
        4: begin b = x - 1; a = b - z; end
        6: begin a = y - 1; b = a + z; end
        2: begin c = -1 - y; b = c + x; end
        default: ;
      endcase
    end else begin
      a = al; b = sb - ha; c = -ha - sb;
    end
    da = map(a, md); db = map(b, md); dc = map(c, md);
  endtask

  function automatic string tag_of(int md);
    case (md)
      0: return "R3 R4 R9 R5";
      1: return "R3 R4 R6";
      2: return "R3 R4 R7";
      default: return "R3 R4 R8";
    endcase
  endfunction

  task automatic compare(input string tag, input longint ea, input longint eb,
                         input longint ec, input int es, input logic edone);
    vectors++;
    if (done !== edone || sector !== 3'(es) || duty_a !== 24'(ea) ||
        duty_b !== 24'(eb) || duty_c !== 24'(ec)) begin
      fails++;
      $display("FAIL %s: got done=%0b sec=%0d a=%h b=%h c=%h, expected done=%0b sec=%0d a=%h b=%h c=%h",
               tag, done, sector, duty_a, duty_b, duty_c, edone, es, 24'(ea), 24'(eb), 24'(ec));
    end
  endtask

  task automatic apply(input longint al, input longint be, input int md, input string tag);
    longint ea, eb, ec;
    int es;
    model(al, be, md, ea, eb, ec, es);
    @(negedge clk);
    v_alpha = 24'(al); v_beta = 24'(be); mode = 2'(md); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    compare(tag, ea, eb, ec, es, 1'b1);
  endtask

  initial begin
    fork
      begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    join_none
  end

  initial begin
    longint ea, eb, ec;
    int es;
    repeat (3) @(negedge clk);
    compare("R1 reset", 0, 0, 0, 0, 1'b0);
    rst_n = 1'b1;

    // R2: second start in the busy cycle is ignored, R10: outputs hold afterwards
    model(64'sh100000, 64'sh080000, 0, ea, eb, ec, es);
    @(negedge clk);
    v_alpha = 24'sh100000; v_beta = 24'sh080000; mode = 2'd0; start = 1'b1;
    @(negedge clk);
    v_alpha = -24'sh300000; v_beta = 24'sh123456; mode = 2'd3;
    @(negedge clk);
    start = 1'b0;
    compare("R2 busy ignore", ea, eb, ec, es, 1'b1);
    @(negedge clk);
    compare("R10 hold", ea, eb, ec, es, 1'b0);
    @(negedge clk);
    compare("R2 single pulse", ea, eb, ec, es, 1'b0);

    // R9 saturation boundaries via inverse Clarke phase a
    apply(64'sh1FFFFF, 0, 3, "R9 edge pos");
    if (duty_a !== 24'hFFFFFC) begin fails++; $display("FAIL R9: a=%h expected fffffc", duty_a); end
    vectors++;
    apply(64'sh200000, 0, 3, "R9 sat pos");
    if (duty_a !== 24'hFFFFFF) begin fails++; $display("FAIL R9: a=%h expected ffffff", duty_a); end
    vectors++;
    apply(-64'sh200000, 0, 3, "R9 edge neg");
    if (duty_a !== 24'h000000) begin fails++; $display("FAIL R9: a=%h expected 000000", duty_a); end
    vectors++;
    apply(-64'sh200001, 0, 3, "R9 sat neg");
    if (duty_a !== 24'h000001) begin fails++; $display("FAIL R9: a=%h expected 000001", duty_a); end
    vectors++;

    // R7 sector 0 in top-clamped mode: every phase reads fffff8
    apply(0, 0, 2, "R7 sector0");
    if (duty_a !== 24'hFFFFF8 || duty_c !== 24'hFFFFF8) begin
      fails++; $display("FAIL R7: a=%h c=%h expected fffff8", duty_a, duty_c);
    end
    vectors++;
    apply(64'sh7FFFFF, -64'sh800000, 0, "R4 R9 extreme");
    apply(-64'sh800000, 64'sh7FFFFF, 1, "R4 R6 extreme");

    for (int md = 0; md < 4; md++)
      for (int ia = -18; ia <= 18; ia++)
        for (int ib = -18; ib <= 18; ib++)
          apply(longint'(ia) * 64'sh70000 + longint'(ia) * 37,
                longint'(ib) * 64'sh70000 - longint'(ib) * 11, md, tag_of(md));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule